// File: doc/BRIEF.md
# Display Color Lookup Palette

This block maps 8-bit pixel indices to 18-bit colors for a display controller. It has two sides. The host side is a pair of 32-bit registers: an address pointer and a data window. The host loads the pointer once. Each read or write of the data window then reaches the entry under the pointer and moves the pointer on by one. This lets a whole run of entries be filled or dumped with a single address load. The same 9-bit address space holds three more colors besides the 256 lookup entries: two cursor colors and a border (overscan) color.

The pixel side takes a 2-bit source select and an 8-bit index. One clock later it presents the chosen color on a registered output. Both sides share one clock. When a host data access and a pixel lookup need the storage in the same cycle, the host wins. The pixel output then keeps its previous value for that one extra clock, so the screen shows no corrupted color while the palette is being updated.

Top module: `palette_lut`

## Requirements
- R1: `host_addr_we` loads `host_wdata[8:0]` into the address pointer. The pointer reads back on `host_addr_rdata` from the next cycle, with bits 31:9 always zero. Reset clears the pointer to 0.
- R2: When `host_addr_we` is high, the data strobes of the same cycle are ignored: no entry is written, no read data is captured and the pointer takes the loaded value.
- R3: A data access is a cycle with `host_data_we` or `host_data_re` high and `host_addr_we` low. It is a write if `host_data_we` is high, and a read otherwise. After each data access the pointer increases by one, wrapping from 0x1FF to 0x000.
- R4: Pointer values 0x000–0x0FF address the 256 lookup entries. 0x100 is cursor color A, 0x101 is cursor color B and 0x104 is the border color. A write stores `host_wdata[17:0]` in the addressed entry.
- R5: Pointer values 0x102, 0x103 and 0x105–0x1FF hold no entry. Writes there change nothing and reads there return zero.
- R6: A read access places `{14'b0, entry}` on `host_data_rdata` in the following cycle. The register keeps its value in all other cycles, and reset clears it to 0.
- R7: `pix_sel` selects the color source: 0 is the lookup entry at `pix_index`, 1 is cursor A, 2 is cursor B and 3 is the border color. The result appears on `pix_color` one clock later. Reset clears `pix_color` to 0.
- R8: At a clock edge where a data access occurs, `pix_color` keeps its previous value. At the next edge without an access it follows the selection again.
- R9: A host write at one edge is visible to the pixel lookup made at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared host and pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr_we | input | 1 | Load the address pointer from `host_wdata` |
| host_data_we | input | 1 | Write `host_wdata` to the entry under the pointer |
| host_data_re | input | 1 | Read the entry under the pointer |
| host_wdata | input | 32 | Host write data for both registers |
| host_addr_rdata | output | 32 | Address pointer read-back |
| host_data_rdata | output | 32 | Data captured by the last read access |
| pix_sel | input | 2 | Pixel color source select |
| pix_index | input | 8 | Pixel index into the lookup entries |
| pix_color | output | 18 | Registered pixel color |

## Verification
The bench builds the block with its default widths: a 9-bit pointer, 8-bit index and 18-bit color. At these widths the pointer wrap at 0x1FF, both reserved holes and the invalid upper range are reachable within a few hundred cycles. Random address loads are biased toward the top of the lookup range and the extended page, so sequential runs cross from lookup entries into cursor, reserved and border slots. Strobe combinations include the address-load-plus-data case and back-to-back accesses. These stretch the output hold over several edges.

// File: rtl/pal_pkg.sv
package pal_pkg;

    // Pixel-side color source select
    typedef enum logic [1:0] {
        PIX_INDEX   = 2'd0,
        PIX_CURSORA = 2'd1,
        PIX_CURSORB = 2'd2,
        PIX_BORDER  = 2'd3
    } pix_src_e;

    // Decoded target of the host pointer
    typedef enum logic [2:0] {
        SLOT_STD    = 3'd0,
        SLOT_CURA   = 3'd1,
        SLOT_CURB   = 3'd2,
        SLOT_BORDER = 3'd3,
        SLOT_NONE   = 3'd4
    } slot_e;

    // One host data access as seen by the storage
    typedef struct packed {
        logic  valid;
        logic  wr;
        slot_e slot;
    } host_op_t;

    // Offset inside the extended page -> slot
    function automatic slot_e ext_slot(input logic [2:0] ofs);
        case (ofs)
            3'd0:    return SLOT_CURA;
            3'd1:    return SLOT_CURB;
            3'd4:    return SLOT_BORDER;
            default: return SLOT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pal_host_port.sv
module pal_host_port
    import pal_pkg::*;
#(
    parameter int ADDR_W  = 9,
    parameter int IDX_W   = 8,
    parameter int COLOR_W = 18,
    parameter int REG_W   = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               addr_we,
    input  logic               data_we,
    input  logic               data_re,
    input  logic [REG_W-1:0]   wdata,
    input  logic [COLOR_W-1:0] rd_color,
    output logic [IDX_W-1:0]   host_idx,
    output host_op_t           op,
    output logic [COLOR_W-1:0] wr_color,
    output logic [REG_W-1:0]   addr_rdata,
    output logic [REG_W-1:0]   data_rdata
);
    localparam int PAGE_W  = ADDR_W - IDX_W;
    localparam int A_PAD   = REG_W - ADDR_W;
    localparam int C_PAD   = REG_W - COLOR_W;
    localparam logic [PAGE_W-1:0] PAGE_STD = '0;
    localparam logic [PAGE_W-1:0] PAGE_EXT = PAGE_W'(1);

    logic [ADDR_W-1:0] ptr_q;
    logic [REG_W-1:0]  rdata_q;
    logic [PAGE_W-1:0] page;
    slot_e             slot;
    logic              access;
    logic              is_read;
    logic              unused_hi;

    // Decode pointer into a storage slot
    always_comb begin
        page = ptr_q[ADDR_W-1:IDX_W];
        if (page == PAGE_STD) begin
            slot = SLOT_STD;
        end else if (page == PAGE_EXT && ptr_q[IDX_W-1:3] == '0) begin
            slot = ext_slot(ptr_q[2:0]);
        end else begin
            slot = SLOT_NONE;
        end
    end

    // Address load beats any data strobe in the same cycle
    assign access  = (data_we | data_re) & ~addr_we;
    assign is_read = access & ~data_we;

    always_comb begin
        op.valid = access;
        op.wr    = data_we;
        op.slot  = slot;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (addr_we) begin
            ptr_q <= wdata[ADDR_W-1:0];
        end else if (access) begin
            ptr_q <= ptr_q + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (is_read) begin
            rdata_q <= (slot == SLOT_NONE) ? '0 : {{C_PAD{1'b0}}, rd_color};
        end
    end

    assign host_idx   = ptr_q[IDX_W-1:0];
    assign wr_color   = wdata[COLOR_W-1:0];
    assign addr_rdata = {{A_PAD{1'b0}}, ptr_q};
    assign data_rdata = rdata_q;
    assign unused_hi  = ^wdata[REG_W-1:COLOR_W];

endmodule

// File: rtl/pal_store.sv
module pal_store
    import pal_pkg::*;
#(
    parameter int IDX_W   = 8,
    parameter int COLOR_W = 18
) (
    input  logic               clk,
    input  logic               rst,
    input  host_op_t           op,
    input  logic [IDX_W-1:0]   host_idx,
    input  logic [COLOR_W-1:0] wr_color,
    input  logic [IDX_W-1:0]   pix_idx,
    output logic [COLOR_W-1:0] host_color,
    output logic [COLOR_W-1:0] pix_std,
    output logic [COLOR_W-1:0] cur_a,
    output logic [COLOR_W-1:0] cur_b,
    output logic [COLOR_W-1:0] border
);
    localparam int NUM_STD = 1 << IDX_W;

    logic [COLOR_W-1:0] lut [NUM_STD];
    logic [COLOR_W-1:0] cur_a_q;
    logic [COLOR_W-1:0] cur_b_q;
    logic [COLOR_W-1:0] border_q;
    logic               wr;

    assign wr = op.valid & op.wr;

    // Lookup entries
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < NUM_STD; e++) begin
                lut[e] <= '0;
            end
        end else if (wr && op.slot == SLOT_STD) begin
            lut[host_idx] <= wr_color;
        end
    end

    // Extended entries
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_a_q  <= '0;
            cur_b_q  <= '0;
            border_q <= '0;
        end else if (wr) begin
            case (op.slot)
                SLOT_CURA:   cur_a_q  <= wr_color;
                SLOT_CURB:   cur_b_q  <= wr_color;
                SLOT_BORDER: border_q <= wr_color;
                default:     ;
            endcase
        end
    end

    always_comb begin
        case (op.slot)
            SLOT_STD:    host_color = lut[host_idx];
            SLOT_CURA:   host_color = cur_a_q;
            SLOT_CURB:   host_color = cur_b_q;
            SLOT_BORDER: host_color = border_q;
            default:     host_color = '0;
        endcase
    end

    assign pix_std = lut[pix_idx];
    assign cur_a   = cur_a_q;
    assign cur_b   = cur_b_q;
    assign border  = border_q;

endmodule

// File: rtl/pal_pixel_out.sv
module pal_pixel_out
    import pal_pkg::*;
#(
    parameter int COLOR_W = 18
) (
    input  logic               clk,
    input  logic               rst,
    input  pix_src_e           sel,
    input  logic [COLOR_W-1:0] std_color,
    input  logic [COLOR_W-1:0] cur_a,
    input  logic [COLOR_W-1:0] cur_b,
    input  logic [COLOR_W-1:0] border,
    input  logic               hold,
    output logic [COLOR_W-1:0] color
);
    logic [COLOR_W-1:0] nxt;
    logic [COLOR_W-1:0] color_q;

    always_comb begin
        case (sel)
            PIX_INDEX:   nxt = std_color;
            PIX_CURSORA: nxt = cur_a;
            PIX_CURSORB: nxt = cur_b;
            default:     nxt = border;
        endcase
    end

    // Hold covers the lookup displaced by a host access
    always_ff @(posedge clk) begin
        if (rst) begin
            color_q <= '0;
        end else if (!hold) begin
            color_q <= nxt;
        end
    end

    assign color = color_q;

endmodule

// File: rtl/palette_lut.sv
module palette_lut
    import pal_pkg::*;
#(
    parameter int ADDR_W  = 9,
    parameter int IDX_W   = 8,
    parameter int COLOR_W = 18,
    parameter int REG_W   = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_addr_we,
    input  logic               host_data_we,
    input  logic               host_data_re,
    input  logic [REG_W-1:0]   host_wdata,
    output logic [REG_W-1:0]   host_addr_rdata,
    output logic [REG_W-1:0]   host_data_rdata,
    input  logic [1:0]         pix_sel,
    input  logic [IDX_W-1:0]   pix_index,
    output logic [COLOR_W-1:0] pix_color
);
    host_op_t           op;
    logic [IDX_W-1:0]   host_idx;
    logic [COLOR_W-1:0] wr_color;
    logic [COLOR_W-1:0] host_color;
    logic [COLOR_W-1:0] pix_std;
    logic [COLOR_W-1:0] cur_a;
    logic [COLOR_W-1:0] cur_b;
    logic [COLOR_W-1:0] border;

    pal_host_port #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .COLOR_W(COLOR_W),
        .REG_W  (REG_W)
    ) u_host (
        .clk       (clk),
        .rst       (rst),
        .addr_we   (host_addr_we),
        .data_we   (host_data_we),
        .data_re   (host_data_re),
        .wdata     (host_wdata),
        .rd_color  (host_color),
        .host_idx  (host_idx),
        .op        (op),
        .wr_color  (wr_color),
        .addr_rdata(host_addr_rdata),
        .data_rdata(host_data_rdata)
    );

    pal_store #(
        .IDX_W  (IDX_W),
        .COLOR_W(COLOR_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .host_idx  (host_idx),
        .wr_color  (wr_color),
        .pix_idx   (pix_index),
        .host_color(host_color),
        .pix_std   (pix_std),
        .cur_a     (cur_a),
        .cur_b     (cur_b),
        .border    (border)
    );

    pal_pixel_out #(
        .COLOR_W(COLOR_W)
    ) u_pix (
        .clk      (clk),
        .rst      (rst),
        .sel      (pix_src_e'(pix_sel)),
        .std_color(pix_std),
        .cur_a    (cur_a),
        .cur_b    (cur_b),
        .border   (border),
        .hold     (op.valid),
        .color    (pix_color)
    );

endmodule

// File: rtl/pal_checker.sv
module pal_checker #(
    parameter int ADDR_W  = 9,
    parameter int IDX_W   = 8,
    parameter int COLOR_W = 18,
    parameter int REG_W   = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               host_addr_we,
    input logic               host_data_we,
    input logic               host_data_re,
    input logic [REG_W-1:0]   host_wdata,
    input logic [REG_W-1:0]   host_addr_rdata,
    input logic [REG_W-1:0]   host_data_rdata,
    input logic [COLOR_W-1:0] pix_color
);
    localparam logic [ADDR_W-1:0] EXT_BASE = ADDR_W'(1 << IDX_W);

    logic [ADDR_W-1:0] ptr;
    logic              acc;
    logic              rd;
    logic              hole;
    logic              unused_chk;

    assign ptr  = host_addr_rdata[ADDR_W-1:0];
    assign acc  = (host_data_we | host_data_re) & ~host_addr_we;
    assign rd   = acc & ~host_data_we;
    assign hole = (ptr == EXT_BASE + ADDR_W'(2)) || (ptr == EXT_BASE + ADDR_W'(3))
               || (ptr > EXT_BASE + ADDR_W'(4));
    assign unused_chk = ^{host_wdata[REG_W-1:ADDR_W], host_addr_rdata[REG_W-1:ADDR_W]};

    assert_addr_load_R1: assert property (@(posedge clk) disable iff (rst)
        host_addr_we |=> ptr == $past(host_wdata[ADDR_W-1:0]));

    assert_load_beats_data_R2: assert property (@(posedge clk) disable iff (rst)
        (host_addr_we && (host_data_we || host_data_re)) |=> $stable(host_data_rdata));

    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (rst)
        acc |=> ptr == ADDR_W'($past(ptr) + ADDR_W'(1)));

    assert_hole_reads_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (rd && hole) |=> host_data_rdata == '0);

    assert_rdata_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(host_data_rdata));

    assert_pixel_hold_R8: assert property (@(posedge clk) disable iff (rst)
        acc |=> $stable(pix_color));

endmodule

bind palette_lut pal_checker #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .COLOR_W(COLOR_W),
    .REG_W  (REG_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .host_addr_we   (host_addr_we),
    .host_data_we   (host_data_we),
    .host_data_re   (host_data_re),
    .host_wdata     (host_wdata),
    .host_addr_rdata(host_addr_rdata),
    .host_data_rdata(host_data_rdata),
    .pix_color      (pix_color)
);

// File: tb/sim_palette_lut.sv
module sim_palette_lut;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        awe = 1'b0;
    logic        dwe = 1'b0;
    logic        dre = 1'b0;
    logic [31:0] wd  = '0;
    logic [1:0]  sel = '0;
    logic [7:0]  idx = '0;
    wire  [31:0] ard;
    wire  [31:0] drd;
    wire  [17:0] pc;

    always #10 clk = ~clk;

    palette_lut u0 (
        .clk            (clk),
        .rst            (rst),
        .host_addr_we   (awe),
        .host_data_we   (dwe),
        .host_data_re   (dre),
        .host_wdata     (wd),
        .host_addr_rdata(ard),
        .host_data_rdata(drd),
        .pix_sel        (sel),
        .pix_index      (idx),
        .pix_color      (pc)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Behavioural reference model
    logic [17:0] m_std [256];
    logic [17:0] m_ca, m_cb, m_bd;
    int          m_ptr;
    logic [31:0] m_rd;
    logic [17:0] m_pix;

    function automatic logic [17:0] m_read(input int a);
        if (a < 256)   return m_std[a];
        if (a == 256)  return m_ca;
        if (a == 257)  return m_cb;
        if (a == 260)  return m_bd;
        return 18'h0;
    endfunction

    always @(posedge clk) begin : model
        logic [17:0] nxt;
        logic        acc;
        if (rst) begin
            for (int e = 0; e < 256; e++) m_std[e] = '0;
            m_ca = '0; m_cb = '0; m_bd = '0;
            m_ptr = 0; m_rd = '0; m_pix = '0;
        end else begin
            case (sel)
                2'd0:    nxt = m_std[idx];
                2'd1:    nxt = m_ca;
                2'd2:    nxt = m_cb;
                default: nxt = m_bd;
            endcase
            acc = (dwe || dre) && !awe;
            if (!acc) m_pix = nxt;
            if (awe) begin
                m_ptr = int'(wd[8:0]);
            end else if (acc) begin
                if (dwe) begin
                    if (m_ptr < 256)       m_std[m_ptr] = wd[17:0];
                    else if (m_ptr == 256) m_ca = wd[17:0];
                    else if (m_ptr == 257) m_cb = wd[17:0];
                    else if (m_ptr == 260) m_bd = wd[17:0];
                end else begin
                    m_rd = {14'h0, m_read(m_ptr)};
                end
                m_ptr = (m_ptr + 1) % 512;
            end
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R1 pointer vs model", ard, 32'(m_ptr));
            chk("R6 read data vs model", drd, m_rd);
            chk("R7 pixel vs model", {14'h0, pc}, {14'h0, m_pix});
        end
    end

    task automatic cyc(input logic a, input logic w, input logic r,
                       input logic [31:0] d, input logic [1:0] s, input logic [7:0] i);
        awe = a; dwe = w; dre = r; wd = d; sel = s; idx = i;
        @(negedge clk);
    endtask

    task automatic idle(input logic [1:0] s, input logic [7:0] i);
        cyc(1'b0, 1'b0, 1'b0, 32'h0, s, i);
    endtask

    logic [31:0] saved;

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset pointer", ard, 32'h0);
        chk("R6 reset read data", drd, 32'h0);
        chk("R7 reset pixel", {14'h0, pc}, 32'h0);
        rst = 1'b0;

        // R1: load with junk in upper bits
        cyc(1, 0, 0, 32'hFFFF_F0FE, 0, 0);
        chk("R1 load 0x0FE upper zero", ard, 32'h0000_00FE);

        // R3/R4: sequential writes across the page boundary
        cyc(0, 1, 0, 32'h0001_1111, 0, 0);
        cyc(0, 1, 0, 32'h0002_2222, 0, 0);
        cyc(0, 1, 0, 32'h0003_3333, 0, 0);
        cyc(0, 1, 0, 32'h0000_0444, 0, 0);
        chk("R3 pointer after four writes", ard, 32'h102);
        cyc(0, 1, 0, 32'h0003_FFFF, 0, 0);
        cyc(0, 1, 0, 32'h0003_FFFF, 0, 0);
        cyc(0, 1, 0, 32'h0001_5555, 0, 0);
        chk("R3 pointer after hole writes", ard, 32'h105);

        // R5: holes read zero
        cyc(1, 0, 0, 32'h102, 0, 0);
        cyc(0, 0, 1, 32'h0, 0, 0);
        chk("R5 read 0x102 zero", drd, 32'h0);
        chk("R3 pointer after read", ard, 32'h103);

        // R4: read back sequence
        cyc(1, 0, 0, 32'h0FE, 0, 0);
        cyc(0, 0, 1, 32'h0, 0, 0);
        chk("R4 entry 0xFE", drd, 32'h0001_1111);
        cyc(0, 0, 1, 32'h0, 0, 0);
        chk("R4 entry 0xFF", drd, 32'h0002_2222);
        cyc(0, 0, 1, 32'h0, 0, 0);
        chk("R4 cursor A", drd, 32'h0003_3333);
        cyc(0, 0, 1, 32'h0, 0, 0);
        chk("R4 cursor B", drd, 32'h0000_0444);
        cyc(0, 0, 1, 32'h0, 0, 0);
        chk("R5 read 0x102 after write", drd, 32'h0);
        cyc(0, 0, 1, 32'h0, 0, 0);
        chk("R5 read 0x103 after write", drd, 32'h0);
        cyc(0, 0, 1, 32'h0, 0, 0);
        chk("R4 border", drd, 32'h0001_5555);

        // R3 wrap, R5 ignored write at 0x1FF
        cyc(1, 0, 0, 32'h1FF, 0, 0);
        cyc(0, 1, 0, 32'h0003_AAAA, 0, 0);
        chk("R3 wrap to zero", ard, 32'h0);
        cyc(1, 0, 0, 32'h1FF, 0, 0);
        cyc(0, 0, 1, 32'h0, 0, 0);
        chk("R5 invalid 0x1FF reads zero", drd, 32'h0);

        // R2: address load with data write in same cycle
        cyc(1, 1, 0, 32'h0000_0005, 0, 0);
        chk("R2 load wins", ard, 32'h5);
        cyc(0, 0, 1, 32'h0, 0, 0);
        chk("R2 entry 5 not written", drd, 32'h0);

        // R7: source select
        idle(0, 8'hFE); chk("R7 index 0xFE", {14'h0, pc}, 32'h0001_1111);
        idle(1, 8'h00); chk("R7 cursor A", {14'h0, pc}, 32'h0003_3333);
        idle(2, 8'h00); chk("R7 cursor B", {14'h0, pc}, 32'h0000_0444);
        idle(3, 8'h00); chk("R7 border", {14'h0, pc}, 32'h0001_5555);

        // R8: hold during a read, resume after
        cyc(0, 0, 1, 32'h0, 0, 8'hFF);
        chk("R8 held on read", {14'h0, pc}, 32'h0001_5555);
        idle(0, 8'hFF);
        chk("R8 resume", {14'h0, pc}, 32'h0002_2222);

        // R9: write visible to next lookup; held during the write
        cyc(1, 0, 0, 32'h010, 0, 8'h10);
        cyc(0, 1, 0, 32'h0002_BEEF, 0, 8'h10);
        chk("R8 held on write", {14'h0, pc}, 32'h0);
        idle(0, 8'h10);
        chk("R9 new entry seen", {14'h0, pc}, 32'h0002_BEEF);

        // R6: read data keeps its value across idle cycles
        saved = drd;
        idle(1, 0); idle(2, 0);
        chk("R6 read data kept", drd, saved);

        // Random phase, compared against the model every clock
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            logic [31:0] d;
            r = $urandom;
            d = $urandom;
            if (r[2:0] == 3'd0) begin
                if (r[3]) d[8:0] = {1'b0, 5'h1F, r[6:4]};
                else      d[8:0] = {1'b1, 5'h0, r[6:4]};
                if (r[7]) d[8:0] = {4'hF, r[8], r[6:4]} | 9'h100;
            end
            cyc(r[2:0] == 3'd0, r[10:9] == 2'd0, r[12:11] == 2'd0, d, r[14:13], r[22:15]);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not finish got=hung exp=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule